// File: doc/BRIEF.md
# Anti-Parallel Converter Group Selector

This block decides which of the two anti-parallel thyristor groups of one output phase, the positive group or the negative group, may receive firing pulses. It is used in a cycloconverter that runs without circulating current. Upstream logic supplies the sign of the fundamental load current and a strobe that marks each zero crossing of that fundamental. The block acts on a crossing only when the strobe rises. Changes of the sign between strobes have no effect, so a current that falls to zero several times within one half-period does not make the groups switch.

When an accepted crossing reverses the group, the block can hold both enables low for a programmable number of clock cycles. This gives the outgoing thyristors time to turn off before the incoming group fires. A mode input can select an overlap instead. In that mode the incoming group is enabled at once, and the outgoing group stays enabled for the same number of cycles. After reset neither group is enabled. The first accepted crossing then enables the group that matches its sign, with no interval.

Top module: `conv_group_sel`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted crossing, both enables are low. The first accepted crossing enables the group of its sign from the next clock edge, with no interval.
- R2: pol_i = 1 means positive current and selects the P group (en_p_o). pol_i = 0 selects the N group (en_n_o).
- R3: A change of pol_i with no strobe has no effect on the enables. A crossing whose sign matches the active group also has no effect.
- R4: A crossing is accepted only in the cycle where zc_strobe_i is high after being low in the previous cycle. A strobe held high is accepted once, even if pol_i changes while it stays high.
- R5: In blanking mode, a crossing that reverses the group drives both enables low for D cycles, starting at the clock edge that accepts it. The incoming group is enabled at the next edge after those D cycles. D = 0 behaves as D = 1.
- R6: D is sampled from dead_cnt_i at the accepted crossing. Changes to dead_cnt_i during the interval have no effect on its length.
- R7: A crossing accepted during the interval sets the group that follows the interval. The last such crossing decides. If the sign returns to the outgoing group, the interval still runs to its end, and then the original group is enabled again.
- R8: In overlap mode (overlap_i = 1), a reversing crossing enables the incoming group at once. Both enables stay high for D cycles, and then only the group chosen under R7 remains enabled.
- R9: overlap_i is sampled at the reversing crossing. Changes to it during the interval have no effect.
- R10: Outside an overlap interval, at most one enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pol_i | input | 1 | Sign of the fundamental load current, 1 = positive |
| zc_strobe_i | input | 1 | Zero-crossing strobe of the fundamental; acted on at its rising edge |
| dead_cnt_i | input | CNT_W | Interval length D in clock cycles |
| overlap_i | input | 1 | 1 = overlap at a changeover, 0 = both groups blanked |
| en_p_o | output | 1 | Firing enable for the positive group |
| en_n_o | output | 1 | Firing enable for the negative group |

## Verification
The assertions assume that pol_i and zc_strobe_i are synchronous to clk_i and already qualified. They also assume that a crossing means a one-or-more-cycle high level on the strobe, preceded by a low cycle. The stimulus changes every input at the falling clock edge and drops the strobe between crossings, except where R4 holds it high on purpose. It keeps D small so that each interval can be counted cycle by cycle, and it covers D = 0, returns during an interval in both modes, and a mode change made during an overlap.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_P_ACT   = 3'd1,
    ST_BLANK_N = 3'd2,
    ST_N_ACT   = 3'd3,
    ST_BLANK_P = 3'd4
  } grp_state_e;
endpackage

// File: rtl/cgs_zc_edge.sv
module cgs_zc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zc_strobe_i,
  input  logic pol_i,
  output logic acc_o,
  output logic acc_pol_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b1;  // a strobe high out of reset is not a fresh edge
    else         strobe_q <= zc_strobe_i;
  end

  assign acc_o     = zc_strobe_i & ~strobe_q;
  assign acc_pol_o = pol_i;

  p_single_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> !acc_o);
endmodule

// File: rtl/cgs_dead_timer.sv
module cgs_dead_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (run_i && cnt_q > ONE) cnt_q <= cnt_q - ONE;
  end

  // zero and one both end the interval after its first cycle
  assign done_o = (cnt_q <= ONE);

  p_load_sample_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

  p_no_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q != '0));
endmodule

// File: rtl/cgs_group_fsm.sv
module cgs_group_fsm
  import cgs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic acc_pol_i,
  input  logic overlap_i,
  input  logic tmr_done_i,
  output logic load_o,
  output logic run_o,
  output logic en_p_o,
  output logic en_n_o
);
  grp_state_e state_q, state_d;
  logic       ovl_q, ovl_d;
  logic       tgt_q, tgt_d;  // 1 = P follows the interval
  logic       blank;

  assign blank  = (state_q == ST_BLANK_N) || (state_q == ST_BLANK_P);
  assign load_o = acc_i && (((state_q == ST_P_ACT) && !acc_pol_i) ||
                            ((state_q == ST_N_ACT) &&  acc_pol_i));
  assign run_o  = blank;

  always_comb begin
    state_d = state_q;
    ovl_d   = ovl_q;
    tgt_d   = tgt_q;
    unique case (state_q)
      ST_INIT: if (acc_i) state_d = acc_pol_i ? ST_P_ACT : ST_N_ACT;
      ST_P_ACT, ST_N_ACT: begin
        if (load_o) begin
          state_d = acc_pol_i ? ST_BLANK_P : ST_BLANK_N;
          ovl_d   = overlap_i;
          tgt_d   = acc_pol_i;
        end
      end
      ST_BLANK_N, ST_BLANK_P: begin
        if (acc_i) tgt_d = acc_pol_i;
        if (tmr_done_i) state_d = tgt_d ? ST_P_ACT : ST_N_ACT;
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      ovl_q   <= 1'b0;
      tgt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovl_q   <= ovl_d;
      tgt_q   <= tgt_d;
    end
  end

  assign en_p_o = (state_q == ST_P_ACT) || (blank && ovl_q);
  assign en_n_o = (state_q == ST_N_ACT) || (blank && ovl_q);

  p_one_group_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_p_o && en_n_o) |-> ovl_q);

  p_change_on_event_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |-> $past(acc_i || tmr_done_i));

  p_first_direct_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT && acc_i) |=> (en_p_o == $past(acc_pol_i)) && (en_n_o == !$past(acc_pol_i)));

  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank && !load_o && !(tmr_done_i)) |=> $stable(ovl_q));
endmodule

// File: rtl/conv_group_sel.sv
module conv_group_sel #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pol_i,
  input  logic             zc_strobe_i,
  input  logic [CNT_W-1:0] dead_cnt_i,
  input  logic             overlap_i,
  output logic             en_p_o,
  output logic             en_n_o
);
  logic acc, acc_pol, load, run, tmr_done;

  cgs_zc_edge i_zc_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .zc_strobe_i (zc_strobe_i),
    .pol_i       (pol_i),
    .acc_o       (acc),
    .acc_pol_o   (acc_pol)
  );

  cgs_dead_timer #(.CNT_W(CNT_W)) i_dead_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (dead_cnt_i),
    .run_i      (run),
    .done_o     (tmr_done)
  );

  cgs_group_fsm i_group_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .acc_pol_i  (acc_pol),
    .overlap_i  (overlap_i),
    .tmr_done_i (tmr_done),
    .load_o     (load),
    .run_o      (run),
    .en_p_o     (en_p_o),
    .en_n_o     (en_n_o)
  );

  p_blank_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !overlap_i) |=> (!en_p_o && !en_n_o));

  p_overlap_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && overlap_i) |=> (en_p_o && en_n_o));
endmodule

// File: tb/test_conv_group_sel.sv
module test_conv_group_sel;
  localparam int CNT_W = 8;
  localparam int NV    = 25;

  typedef struct packed {
    logic             pol;
    logic             stb;
    logic             ovl;
    logic [CNT_W-1:0] dead;
    logic             ep;
    logic             en;
    logic [3:0]       req;
  } vec_t;

  // inputs applied for one cycle; expected outputs after the following rising edge
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,8'd3,1'b0,1'b0,4'd1},  // 0  R1 idle before first crossing
    '{1'b1,1'b1,1'b0,8'd3,1'b1,1'b0,4'd1},  // 1  R1 R2 first crossing direct to P
    '{1'b0,1'b0,1'b0,8'd3,1'b1,1'b0,4'd3},  // 2  R3 sign flip without strobe
    '{1'b1,1'b0,1'b0,8'd3,1'b1,1'b0,4'd3},  // 3
    '{1'b1,1'b1,1'b0,8'd3,1'b1,1'b0,4'd3},  // 4  R3 same-sign crossing
    '{1'b0,1'b1,1'b0,8'd3,1'b1,1'b0,4'd4},  // 5  R4 strobe held, sign flips
    '{1'b0,1'b0,1'b0,8'd3,1'b1,1'b0,4'd4},  // 6
    '{1'b0,1'b1,1'b0,8'd3,1'b0,1'b0,4'd5},  // 7  R5 blank cycle 1
    '{1'b0,1'b0,1'b0,8'd9,1'b0,1'b0,4'd6},  // 8  R6 D change ignored
    '{1'b0,1'b0,1'b0,8'd9,1'b0,1'b0,4'd5},  // 9  R5 blank cycle 3
    '{1'b0,1'b0,1'b0,8'd9,1'b0,1'b1,4'd2},  // 10 R2 R5 N enabled
    '{1'b1,1'b1,1'b0,8'd4,1'b0,1'b0,4'd5},  // 11 R5 toward P
    '{1'b0,1'b0,1'b0,8'd4,1'b0,1'b0,4'd7},  // 12
    '{1'b0,1'b1,1'b0,8'd4,1'b0,1'b0,4'd7},  // 13 R7 return to N
    '{1'b0,1'b0,1'b0,8'd4,1'b0,1'b0,4'd7},  // 14 interval still runs
    '{1'b0,1'b0,1'b0,8'd4,1'b0,1'b1,4'd7},  // 15 R7 N again
    '{1'b1,1'b1,1'b1,8'd2,1'b1,1'b1,4'd8},  // 16 R8 overlap start
    '{1'b1,1'b0,1'b0,8'd2,1'b1,1'b1,4'd9},  // 17 R9 mode drop ignored
    '{1'b1,1'b0,1'b0,8'd2,1'b1,1'b0,4'd8},  // 18 R8 P only
    '{1'b0,1'b1,1'b0,8'd0,1'b0,1'b0,4'd5},  // 19 R5 D=0 as one cycle
    '{1'b0,1'b0,1'b0,8'd0,1'b0,1'b1,4'd5},  // 20
    '{1'b1,1'b1,1'b1,8'd3,1'b1,1'b1,4'd8},  // 21 R8 overlap toward P
    '{1'b1,1'b0,1'b1,8'd3,1'b1,1'b1,4'd8},  // 22
    '{1'b0,1'b1,1'b1,8'd3,1'b1,1'b1,4'd7},  // 23 R7 return during overlap
    '{1'b0,1'b0,1'b1,8'd3,1'b0,1'b1,4'd7}   // 24 R7 N only
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pol_i = 1'b0;
  logic             zc_strobe_i = 1'b0;
  logic [CNT_W-1:0] dead_cnt_i = '0;
  logic             overlap_i = 1'b0;
  logic             en_p_o, en_n_o;
  int               n_chk = 0;
  int               n_fail = 0;
  bit               done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  conv_group_sel #(.CNT_W(CNT_W)) i_conv_group_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pol_i       (pol_i),
    .zc_strobe_i (zc_strobe_i),
    .dead_cnt_i  (dead_cnt_i),
    .overlap_i   (overlap_i),
    .en_p_o      (en_p_o),
    .en_n_o      (en_n_o)
  );

  task automatic check(input string req, input logic ep, input logic en);
    n_chk++;
    if (en_p_o !== ep || en_n_o !== en) begin
      n_fail++;
      $display("FAIL %s: p/n = %b%b, expected %b%b", req, en_p_o, en_n_o, ep, en);
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", 1'b0, 1'b0);  // R1 held in reset
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      pol_i       = VECS[i].pol;
      zc_strobe_i = VECS[i].stb;
      overlap_i   = VECS[i].ovl;
      dead_cnt_i  = VECS[i].dead;
      @(posedge clk_i);
      @(negedge clk_i);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].ep, VECS[i].en);
    end

    // R1: asynchronous reset while N is active
    #1 rst_ni = 1'b0;
    #0.5 check("R1 async", 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    pol_i = 1'b0; zc_strobe_i = 1'b1;  // strobe high right out of reset: no fresh edge
    @(posedge clk_i); @(negedge clk_i);
    check("R4 held from reset", 1'b0, 1'b0);
    zc_strobe_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    zc_strobe_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    check("R1 first to N", 1'b0, 1'b1);
    zc_strobe_i = 1'b0;

    // R5: count a longer blank interval at the ports
    begin
      int blank_cycles = 0;
      dead_cnt_i = 8'd7; overlap_i = 1'b0;
      @(posedge clk_i); @(negedge clk_i);
      pol_i = 1'b1; zc_strobe_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      zc_strobe_i = 1'b0;
      while (!en_p_o && !en_n_o && blank_cycles < 50) begin
        blank_cycles++;
        @(posedge clk_i); @(negedge clk_i);
      end
      n_chk++;
      if (blank_cycles != 7) begin
        n_fail++;
        $display("FAIL R5: blank cycles = %0d, expected 7", blank_cycles);
      end
      check("R5 P after interval", 1'b1, 1'b0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule